// File: doc/BRIEF.md
# One-wire bus master engine

This block masters a single open-drain one-wire data line. A short command interface starts one of four operations: a bus reset that detects whether any device is present, a byte write, a byte read, or a single-bit touch that writes one bit and returns the level seen on the line. The line is modelled as two separate signals: a drive-low output, which an external open-drain pad turns into a pulled-down line, and the sampled line level, which comes back as an input.

Every phase of every slot is measured in microseconds. A divider, sized from the clock-frequency parameter, produces a one-microsecond tick. The divider restarts at the start of each slot, so each phase lasts an exact number of clocks. Software may arm a one-shot strong pull-up with a length in milliseconds. The pull-up then switches on after the last slot of the next byte write and clears its own request. A request of zero withdraws an armed one.

While the block works, `busy` is high and new commands are ignored. Each command ends with a single-cycle `done`. At that point `presence_n` or `rd_data` holds the result.

Top module: `owire_master`

## Requirements
- R1: Command code 0 (reset) drives the line low for exactly RST_LOW_US microseconds and then releases it. `presence_n` becomes 0 if the line is low PRES_WAIT_US microseconds after the release, and 1 otherwise.
- R2: A reset command does not complete (`done`) until at least PRES_WAIT_US + RST_RECOV_US microseconds after the line was released.
- R3: Command code 1 (write) sends `cmd_data` least significant bit first. A 0 bit drives low for ZERO_LOW_US and a 1 bit drives low for ONE_LOW_US. Here a microsecond is CLK_FREQ_HZ/1e6 clocks.
- R4: Within a command, consecutive falling edges of the drive are separated by at least the full slot length: ZERO_LOW_US+ZERO_REC_US for a 0 slot, or ONE_LOW_US+ONE_REL_US for a 1 slot.
- R5: Command code 2 (read) issues eight write-1 slots. It samples the line SAMPLE_US after each falling edge and assembles the bits least significant first into `rd_data`.
- R6: Command code 3 (touch) writes `cmd_data[0]` in one slot and returns the sampled level in `rd_data[0]`, with `rd_data[7:1]` cleared.
- R7: A `pu_req_valid` with non-zero `pu_req_ms`, given while idle, arms a one-shot request. After the last slot of the next write command, `strong_pu` is high for pu_req_ms × US_PER_MS microseconds, with the drive released. Later writes give no pull-up.
- R8: A `pu_req_valid` with `pu_req_ms` = 0 cancels an armed request.
- R9: `cmd_valid` while `busy` is high is ignored: no extra slot and no extra `done`.
- R10: Each accepted command yields exactly one `done` pulse, one clock wide, in the cycle `busy` falls.
- R11: After reset the block is idle with `busy`, `done`, `line_drive_low`, `strong_pu` low, `presence_n` high and `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_op | input | 2 | 0 reset, 1 write byte, 2 read byte, 3 touch bit |
| cmd_data | input | 8 | Byte to write, or bit 0 for touch |
| pu_req_valid | input | 1 | Arm or cancel the one-shot strong pull-up (idle only) |
| pu_req_ms | input | PU_MS_W | Pull-up length in milliseconds, 0 cancels |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence_n | output | 1 | Reset result: 0 device present, 1 none |
| rd_data | output | 8 | Byte read or touch result |
| line_drive_low | output | 1 | Pull the data line low |
| line_in | input | 1 | Sampled data-line level |
| strong_pu | output | 1 | Strong pull-up enable |

## Verification
The embedded assertions assume that the slot engine never receives a start while a slot is still running. They also assume that a pull-up period is never started with a length of zero. Both conditions depend on the command sequencer honouring `busy` and filtering zero-length requests. The bench issues commands and pull-up requests only from idle, apart from one deliberate command sent while busy. It drives the line model from the opposite clock edge. A bit-0 reply lasts well past the sample point and ends before the next slot, and a presence pulse covers the presence sample instant. The whole sweep runs on a two-clocks-per-microsecond configuration with shortened slot times.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_TOUCH = 2'd3
    } owire_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOT = 2'd1,
        ST_PULL = 2'd2
    } owire_st_e;

endpackage

// File: rtl/owire_tick.sv
// Microsecond tick from the system clock; restarted at every slot start
module owire_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_d, div_q;

    assign tick = (div_q == DW'(DIV - 1));

    always_comb begin
        div_d = div_q;
        if (clr)       div_d = '0;
        else if (tick) div_d = '0;
        else           div_d = div_q + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R3: ticks never come back-to-back when a microsecond spans several clocks
            assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && !clr) |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/owire_slot.sv
// One timed slot: a reset/presence slot or a single bit slot
module owire_slot #(
    parameter int RST_LOW_US   = 480,
    parameter int PRES_WAIT_US = 70,
    parameter int RST_RECOV_US = 410,
    parameter int ZERO_LOW_US  = 60,
    parameter int ZERO_REC_US  = 10,
    parameter int ONE_LOW_US   = 6,
    parameter int ONE_REL_US   = 64,
    parameter int SAMPLE_US    = 15,
    parameter int CW           = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_rst,
    input  logic wbit,
    input  logic tick,
    input  logic line_in,
    output logic drive_low,
    output logic slot_done,
    output logic sample
);
    localparam int TOT_RST  = RST_LOW_US + PRES_WAIT_US + RST_RECOV_US;
    localparam int TOT_ZERO = ZERO_LOW_US + ZERO_REC_US;
    localparam int TOT_ONE  = ONE_LOW_US + ONE_REL_US;

    typedef struct packed {
        logic          active;
        logic          is_rst;
        logic          wbit;
        logic          samp;
        logic [CW-1:0] cnt;
    } slot_t;

    slot_t q, d;
    logic [CW-1:0] low_len, smp_at, tot_len;
    logic          hit_smp;

    always_comb begin
        low_len = q.is_rst ? CW'(RST_LOW_US) : (q.wbit ? CW'(ONE_LOW_US) : CW'(ZERO_LOW_US));
        smp_at  = q.is_rst ? CW'(RST_LOW_US + PRES_WAIT_US) : CW'(SAMPLE_US);
        tot_len = q.is_rst ? CW'(TOT_RST) : (q.wbit ? CW'(TOT_ONE) : CW'(TOT_ZERO));
    end

    assign hit_smp   = q.active && tick && ((q.cnt + CW'(1)) == smp_at);
    assign slot_done = q.active && tick && ((q.cnt + CW'(1)) == tot_len);
    assign drive_low = q.active && (q.cnt < low_len);
    assign sample    = q.samp;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.is_rst = is_rst;
            d.wbit   = wbit;
            d.cnt    = '0;
        end else if (q.active && tick) begin
            d.cnt = q.cnt + CW'(1);
            if (hit_smp)   d.samp   = line_in;
            if (slot_done) d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{active: 1'b0, is_rst: 1'b0, wbit: 1'b0, samp: 1'b1, cnt: '0};
        else        q <= d;
    end

    // R4: the sequencer only launches a slot once the previous one has ended
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.active);
endmodule

// File: rtl/owire_pull.sv
// Strong pull-up timer counting whole milliseconds of microsecond ticks
module owire_pull #(
    parameter int US_PER_MS = 1000,
    parameter int MW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] ms,
    input  logic          tick,
    output logic          active,
    output logic          fin
);
    localparam int UW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

    typedef struct packed {
        logic          active;
        logic [UW-1:0] us;
        logic [MW-1:0] left;
    } pull_t;

    pull_t q, d;
    logic  us_end;

    assign us_end = (q.us == UW'(US_PER_MS - 1));
    assign fin    = q.active && tick && us_end && (q.left == MW'(1));
    assign active = q.active;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.us     = '0;
            d.left   = ms;
        end else if (q.active && tick) begin
            if (us_end) begin
                d.us = '0;
                if (q.left == MW'(1)) d.active = 1'b0;
                else                  d.left   = q.left - MW'(1);
            end else begin
                d.us = q.us + UW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a zero-length period must never be launched
    assert_nonzero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (ms != '0));
endmodule

// File: rtl/owire_master.sv
// Command sequencer for the one-wire master
module owire_master
    import owire_pkg::*;
#(
    parameter int CLK_FREQ_HZ  = 100_000_000,
    parameter int RST_LOW_US   = 480,
    parameter int PRES_WAIT_US = 70,
    parameter int RST_RECOV_US = 410,
    parameter int ZERO_LOW_US  = 60,
    parameter int ZERO_REC_US  = 10,
    parameter int ONE_LOW_US   = 6,
    parameter int ONE_REL_US   = 64,
    parameter int SAMPLE_US    = 15,
    parameter int US_PER_MS    = 1000,
    parameter int PU_MS_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [7:0]         cmd_data,
    input  logic               pu_req_valid,
    input  logic [PU_MS_W-1:0] pu_req_ms,
    output logic               busy,
    output logic               done,
    output logic               presence_n,
    output logic [7:0]         rd_data,
    output logic               line_drive_low,
    input  logic               line_in,
    output logic               strong_pu
);
    localparam int CLK_PER_US = (CLK_FREQ_HZ / 1_000_000 > 0) ? CLK_FREQ_HZ / 1_000_000 : 1;
    localparam int TOT_RST    = RST_LOW_US + PRES_WAIT_US + RST_RECOV_US;
    localparam int TOT_ZERO   = ZERO_LOW_US + ZERO_REC_US;
    localparam int TOT_ONE    = ONE_LOW_US + ONE_REL_US;
    localparam int MAX_BIT    = (TOT_ZERO > TOT_ONE) ? TOT_ZERO : TOT_ONE;
    localparam int MAX_TOT    = (TOT_RST > MAX_BIT) ? TOT_RST : MAX_BIT;
    localparam int CW         = $clog2(MAX_TOT + 1);

    typedef struct packed {
        owire_st_e          st;
        owire_op_e          op;
        logic [7:0]         sh;
        logic [2:0]         bidx;
        logic               pu_pend;
        logic [PU_MS_W-1:0] pu_ms;
        logic               slot_go;
        logic               slot_rst;
        logic               slot_bit;
        logic               pu_go;
        logic               done;
        logic               pres_n;
        logic [7:0]         rd;
    } ctl_t;

    ctl_t q, d;

    logic tick, slot_done, slot_sample, pu_fin, pu_active;

    owire_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (q.slot_go | q.pu_go),
        .tick (tick)
    );

    owire_slot #(
        .RST_LOW_US  (RST_LOW_US),
        .PRES_WAIT_US(PRES_WAIT_US),
        .RST_RECOV_US(RST_RECOV_US),
        .ZERO_LOW_US (ZERO_LOW_US),
        .ZERO_REC_US (ZERO_REC_US),
        .ONE_LOW_US  (ONE_LOW_US),
        .ONE_REL_US  (ONE_REL_US),
        .SAMPLE_US   (SAMPLE_US),
        .CW          (CW)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (q.slot_go),
        .is_rst   (q.slot_rst),
        .wbit     (q.slot_bit),
        .tick     (tick),
        .line_in  (line_in),
        .drive_low(line_drive_low),
        .slot_done(slot_done),
        .sample   (slot_sample)
    );

    owire_pull #(.US_PER_MS(US_PER_MS), .MW(PU_MS_W)) u_pull (
        .clk   (clk),
        .rst_n (rst_n),
        .start (q.pu_go),
        .ms    (q.pu_ms),
        .tick  (tick),
        .active(pu_active),
        .fin   (pu_fin)
    );

    always_comb begin
        d         = q;
        d.slot_go = 1'b0;
        d.pu_go   = 1'b0;
        d.done    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (pu_req_valid) begin
                    d.pu_pend = (pu_req_ms != '0);
                    d.pu_ms   = pu_req_ms;
                end
                if (cmd_valid) begin
                    d.op       = owire_op_e'(cmd_op);
                    d.sh       = cmd_data;
                    d.bidx     = '0;
                    d.st       = ST_SLOT;
                    d.slot_go  = 1'b1;
                    d.slot_rst = (owire_op_e'(cmd_op) == OP_RESET);
                    d.slot_bit = (owire_op_e'(cmd_op) == OP_READ) ? 1'b1 : cmd_data[0];
                end
            end
            ST_SLOT: begin
                if (slot_done) begin
                    unique case (q.op)
                        OP_RESET: begin
                            d.pres_n = slot_sample;
                            d.st     = ST_IDLE;
                            d.done   = 1'b1;
                        end
                        OP_TOUCH: begin
                            d.rd   = {7'b0, slot_sample};
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                        default: begin
                            d.sh = (q.op == OP_READ) ? {slot_sample, q.sh[7:1]}
                                                     : {1'b0, q.sh[7:1]};
                            if (q.bidx == 3'd7) begin
                                if (q.op == OP_READ) d.rd = {slot_sample, q.sh[7:1]};
                                if (q.op == OP_WRITE && q.pu_pend) begin
                                    d.st      = ST_PULL;
                                    d.pu_go   = 1'b1;
                                    d.pu_pend = 1'b0;
                                end else begin
                                    d.st   = ST_IDLE;
                                    d.done = 1'b1;
                                end
                            end else begin
                                d.bidx     = q.bidx + 3'd1;
                                d.slot_go  = 1'b1;
                                d.slot_rst = 1'b0;
                                d.slot_bit = (q.op == OP_READ) ? 1'b1 : q.sh[1];
                            end
                        end
                    endcase
                end
            end
            ST_PULL: begin
                if (pu_fin) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.op     <= OP_RESET;
            q.pres_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign presence_n = q.pres_n;
    assign rd_data    = q.rd;
    assign strong_pu  = pu_active;

    // R10: completion is a single-cycle pulse
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: busy only drops together with a completion pulse
    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9: a command offered while busy leaves the running operation untouched
    assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(q.op));
    // R7: the strong pull-up starts only after a byte write, never while driving low
    assert_pu_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strong_pu) |-> (q.op == OP_WRITE));
    assert_pu_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strong_pu |-> !line_drive_low);
    // R3: the line is only driven while a command is in progress
    assert_drive_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> busy);
endmodule

// File: tb/owire_master_test.sv
module owire_master_test;
    localparam int P      = 2;
    localparam int RSTL   = 48;
    localparam int PDS    = 7;
    localparam int RREC   = 41;
    localparam int Z_LOW  = 6;
    localparam int Z_REC  = 2;
    localparam int O_LOW  = 1;
    localparam int O_REL  = 7;
    localparam int SMP    = 3;
    localparam int UPM    = 5;
    localparam int MSW    = 4;
    localparam int BITTOT = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = 2'd0;
    logic [7:0]     cmd_data = 8'd0;
    logic           pu_req_valid = 1'b0;
    logic [MSW-1:0] pu_req_ms = '0;
    logic           busy, done, presence_n, line_drive_low, line_in, strong_pu;
    logic [7:0]     rd_data;

    always #5 clk = ~clk;

    owire_master #(
        .CLK_FREQ_HZ(P * 1_000_000), .RST_LOW_US(RSTL), .PRES_WAIT_US(PDS),
        .RST_RECOV_US(RREC), .ZERO_LOW_US(Z_LOW), .ZERO_REC_US(Z_REC),
        .ONE_LOW_US(O_LOW), .ONE_REL_US(O_REL), .SAMPLE_US(SMP),
        .US_PER_MS(UPM), .PU_MS_W(MSW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .pu_req_valid(pu_req_valid), .pu_req_ms(pu_req_ms),
        .busy(busy), .done(done), .presence_n(presence_n), .rd_data(rd_data),
        .line_drive_low(line_drive_low), .line_in(line_in), .strong_pu(strong_pu)
    );

    int nchk = 0, nerr = 0, cmds = 0;

    // monitor and device model state (written only by the monitor)
    int   cyc = 0, low_run = 0, lows = 0, bad_lows = 0, rst_lows = 0, gap_bad = 0;
    int   last_fall = 0, rel_cyc = 0, done_cnt = 0, done_gap = 0;
    int   pu_run = 0, pu_cnt = 0, pu_len = 0, pu_lows_at_rise = 0;
    int   bcnt = 100, pcnt = 100;
    bit   seen_fall = 0, prev_drv = 0, prev_pu = 0, bval = 1, dev_pull = 0;
    logic [7:0] mbyte = 8'd0;
    logic [2:0] dev_idx = 3'd0;

    // stimulus-owned device configuration
    bit         dev_present = 0, dev_read = 0;
    logic [7:0] dev_byte = 8'hFF;

    assign line_in = !(line_drive_low || dev_pull);

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cmd_valid && !busy) dev_idx = 3'd0;
        if (!prev_drv && line_drive_low) begin
            if (seen_fall && (cyc - last_fall) < BITTOT * P) gap_bad = gap_bad + 1;
            last_fall = cyc;
            seen_fall = 1;
            bcnt      = 0;
            bval      = dev_byte[dev_idx];
            dev_idx   = dev_idx + 3'd1;
        end else if (bcnt < 1000) bcnt = bcnt + 1;
        if (line_drive_low) low_run = low_run + 1;
        if (prev_drv && !line_drive_low) begin
            lows = lows + 1;
            if (low_run == O_LOW * P)      mbyte = {1'b1, mbyte[7:1]};
            else if (low_run == Z_LOW * P) mbyte = {1'b0, mbyte[7:1]};
            else if (low_run == RSTL * P) begin
                rst_lows = rst_lows + 1;
                pcnt     = 0;
            end else bad_lows = bad_lows + 1;
            rel_cyc = cyc;
            low_run = 0;
        end else if (pcnt < 1000) pcnt = pcnt + 1;
        if (strong_pu) pu_run = pu_run + 1;
        if (!prev_pu && strong_pu) pu_lows_at_rise = lows;
        if (prev_pu && !strong_pu) begin
            pu_cnt = pu_cnt + 1;
            pu_len = pu_run;
            pu_run = 0;
        end
        if (done) begin
            done_cnt = done_cnt + 1;
            done_gap = cyc - rel_cyc;
        end
        dev_pull = (dev_read && !bval && bcnt < 10) ||
                   (dev_present && pcnt >= 4 && pcnt < 24);
        prev_drv = line_drive_low;
        prev_pu  = strong_pu;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input int op, input int data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_data  = 8'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmds++;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pu_req(input int ms);
        @(negedge clk);
        pu_req_valid = 1'b1;
        pu_req_ms    = MSW'(ms);
        @(negedge clk);
        pu_req_valid = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int l0, b0, pc0, r0;
        repeat (3) @(negedge clk);
        // R11: idle state after reset
        check(!busy && !done && !line_drive_low && !strong_pu && presence_n && rd_data == 0,
              "R11", {busy, done, line_drive_low, strong_pu, presence_n}, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1/R2: reset with and without a device
        for (int pres = 1; pres >= 0; pres--) begin
            dev_present = bit'(pres);
            r0 = rst_lows;
            run_cmd(0, 0);
            check(rst_lows == r0 + 1, "R1 reset low length", rst_lows - r0, 1);
            check(presence_n == !pres, "R1 presence result", presence_n, !pres);
            check(done_gap >= (PDS + RREC) * P, "R2 recovery", done_gap, (PDS + RREC) * P);
        end
        dev_present = 0;

        // R3: exhaustive byte write
        for (int b = 0; b < 256; b++) begin
            l0 = lows;
            b0 = bad_lows;
            run_cmd(1, b);
            check(lows - l0 == 8 && bad_lows == b0 && mbyte == 8'(b), "R3 write", mbyte, b);
        end

        // R5: exhaustive byte read
        dev_read = 1;
        for (int b = 0; b < 256; b++) begin
            dev_byte = 8'(b);
            l0 = lows;
            run_cmd(2, 0);
            check(rd_data == 8'(b), "R5 read data", rd_data, b);
            check(lows - l0 == 8 && mbyte == 8'hFF, "R5 write-1 slots", mbyte, 255);
        end

        // R6: touch, all four combinations of written bit and device reply
        for (int w = 0; w < 2; w++) begin
            for (int v = 0; v < 2; v++) begin
                dev_byte = v ? 8'hFF : 8'h00;
                l0 = lows;
                run_cmd(3, w);
                check(rd_data == 8'(w & v), "R6 touch result", rd_data, w & v);
                check(lows - l0 == 1 && mbyte[7] == w[0], "R6 touch slot", mbyte[7], w);
            end
        end
        dev_read = 0;
        dev_byte = 8'hFF;

        // R4: slot spacing over everything above
        check(gap_bad == 0, "R4 slot spacing", gap_bad, 0);

        // R7: one-shot strong pull-up after the next write
        pc0 = pu_cnt;
        pu_req(3);
        l0 = lows;
        run_cmd(1, 8'h3C);
        check(pu_cnt == pc0 + 1, "R7 pull-up fired", pu_cnt - pc0, 1);
        check(pu_len == 3 * UPM * P, "R7 pull-up length", pu_len, 3 * UPM * P);
        check(pu_lows_at_rise - l0 == 8, "R7 after last slot", pu_lows_at_rise - l0, 8);
        run_cmd(1, 8'h3C);
        check(pu_cnt == pc0 + 1, "R7 one-shot", pu_cnt - pc0, 1);

        // R8: zero request cancels
        pu_req(2);
        pu_req(0);
        run_cmd(1, 8'h81);
        check(pu_cnt == pc0 + 1, "R8 cancel", pu_cnt - pc0, 1);

        // R9: command while busy is ignored
        l0 = lows;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_data = 8'hA5;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmds++;
        repeat (20) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(lows - l0 == 8 && mbyte == 8'hA5, "R9 write kept", mbyte, 8'hA5);
        repeat (60) @(negedge clk);
        check(lows - l0 == 8 && !busy, "R9 no extra command", lows - l0, 8);

        // R10: one done per accepted command
        check(done_cnt == cmds, "R10 done count", done_cnt, cmds);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule